// File: doc/BRIEF.md
# Paced Parallel ADC Capture Controller

This block sits on the host side of a 12-bit converter that has a parallel result bus. A sample timer running on the system clock raises a conversion-start output once per programmed period. The converter holds its input on that rising edge and, once the conversion is complete, pulses its active-low end-of-conversion line. The block brings that line into the clock domain through a two-flop synchronizer and detects the falling edge. It then uses that edge as its read command: chip-select and read go low together for a fixed number of cycles, and the bus word is captured on the last cycle of that strobe. No interrupt or polling logic is needed.

Each captured word leaves on a valid/ready stream. The block can report it in the converter's native code or in the other format (two's complement or straight binary) by inverting the most significant bit. Two sticky flags report timing problems. The first is raised when the read strobe falls too close to the next conversion start, or when the programmed period is shorter than conversion time plus acquisition time. The second is raised when an end-of-conversion pulse never arrives.

Stream rules: `m_valid` stays high and `m_data` stays unchanged until a cycle in which `m_ready` is high. A result that completes while an earlier one is still waiting is discarded, because the converter cannot be stalled. A result completing in the same cycle as a handshake is taken.

Top module: `adc_capture_top`

## Requirements
- R1: While `enable` is high, `conv_start` rises once every PERIOD_CYC clock cycles and stays high for START_W cycles. The first rise comes on the first clock edge that samples `enable` high. While `enable` is low, `conv_start` stays low.
- R2: If `eoc_n` is first sampled low at clock edge k during a conversion, `cs_n` and `rd_n` both go low at edge k+2.
- R3: `cs_n` and `rd_n` are always equal. They stay low for exactly RD_W cycles after each accepted end-of-conversion edge, and they are high at all other times.
- R4: The bus word is captured on the final clock edge of the read strobe. On that same edge `rd_n` returns high and `m_valid` rises.
- R5: When ADC_BIPOLAR differs from SIGNED_OUT, `m_data` is the captured word with bit 11 inverted (for example 12'h000 becomes 12'h800). When the two parameters are equal, the word passes through unchanged.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold their values. A result that completes during that time is dropped.
- R7: `err_period` is set, and stays set until reset, when `conv_start` rises fewer than GUARD_CYC cycles after `rd_n` fell, or when it rises while a conversion or read is still in progress. A gap of exactly GUARD_CYC cycles does not set it.
- R8: `err_period` is high from reset onward whenever PERIOD_CYC is less than CONV_CYC + ACQ_CYC. Otherwise it is low after reset.
- R9: If no end-of-conversion edge arrives within TIMEOUT_CYC cycles of the start, `err_timeout` is set and stays set until reset. The block then returns to idle without strobing, and the next start is handled normally.
- R10: An `eoc_n` falling edge while no conversion is pending is ignored: no strobe and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the sample timer |
| conv_start | output | 1 | Conversion-start pulse to the converter |
| eoc_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| cs_n | output | 1 | Converter chip-select, active low |
| rd_n | output | 1 | Converter read, active low |
| adc_bus | input | 12 | Converter parallel result bus |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | 12 | Result word after format selection |
| err_period | output | 1 | Sticky read-to-start spacing or period violation |
| err_timeout | output | 1 | Sticky missing end-of-conversion |

## Verification
The bench sets the converter model's end-of-conversion latency so that the read strobe falls exactly GUARD_CYC cycles before the next start, and then one cycle later. A guard comparison that is off by one would set the flag too early or miss it. The bus carries a junk word whenever the strobe is inactive, so a capture taken one cycle late or outside the strobe gives a wrong value. Other scenarios are a stalled consumer while a second result completes, a converter that never answers, and a stray end-of-conversion pulse while idle. A design that overwrites the held word, hangs after a timeout, or strobes on a stray pulse would show a changed `m_data`, no further results, or a spurious strobe.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } adcc_state_t;

  // Switch between two's complement and offset binary by inverting the top bit.
  function automatic logic [11:0] fmt_code(input logic [11:0] raw, input bit flip);
    fmt_code = flip ? {~raw[11], raw[10:0]} : raw;
  endfunction
endpackage

// File: rtl/adcc_timer.sv
module adcc_timer #(
  parameter int PERIOD_CYC = 100,
  parameter int START_W    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic conv_start,
  output logic start_evt
);
  localparam int CNT_W = $clog2(PERIOD_CYC + 1);

  logic [CNT_W-1:0] tcnt;

  assign start_evt = enable && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt       <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= enable && (tcnt < CNT_W'(START_W));
      if (!enable)
        tcnt <= '0;
      else if (tcnt == CNT_W'(PERIOD_CYC - 1))
        tcnt <= '0;
      else
        tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcc_eoc_sync.sv
module adcc_eoc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_n,
  output logic eoc_fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= eoc_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign eoc_fall = s3 && !s2;
endmodule

// File: rtl/adcc_read_fsm.sv
module adcc_read_fsm
  import adcc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 120,
  parameter int RD_W        = 3,
  parameter int GUARD_CYC   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic eoc_fall,
  output logic strobe_n,
  output logic take,
  output logic late_err,
  output logic timeout_err
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int RC_W = $clog2(RD_W + 1);
  localparam int GD_W = $clog2(GUARD_CYC + 1);

  adcc_state_t      state;
  logic [TO_W-1:0]  to_cnt;
  logic [RC_W-1:0]  rd_cnt;
  logic [GD_W-1:0]  since_rd;

  assign take = (state == ST_READ) && (rd_cnt == RC_W'(RD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      to_cnt      <= '0;
      rd_cnt      <= '0;
      strobe_n    <= 1'b1;
      since_rd    <= GD_W'(GUARD_CYC);
      late_err    <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      if (state == ST_CONV && eoc_fall)
        since_rd <= '0;
      else if (since_rd != GD_W'(GUARD_CYC))
        since_rd <= since_rd + 1'b1;

      if (start_evt && (state != ST_IDLE || since_rd < GD_W'(GUARD_CYC - 1)))
        late_err <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state  <= ST_CONV;
            to_cnt <= '0;
          end
        end
        ST_CONV: begin
          if (eoc_fall) begin
            state    <= ST_READ;
            rd_cnt   <= '0;
            strobe_n <= 1'b0;
          end else if (to_cnt == TO_W'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (rd_cnt == RC_W'(RD_W - 1)) begin
            state    <= ST_IDLE;
            strobe_n <= 1'b1;
          end else begin
            rd_cnt <= rd_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcc_out_reg.sv
module adcc_out_reg
  import adcc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter bit FLIP   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (take && (!m_valid || m_ready)) begin
        m_valid <= 1'b1;
        m_data  <= fmt_code(din, FLIP);
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_capture_top.sv
module adc_capture_top #(
  parameter int PERIOD_CYC  = 100,
  parameter int START_W     = 2,
  parameter int CONV_CYC    = 80,
  parameter int ACQ_CYC     = 20,
  parameter int TIMEOUT_CYC = 90,
  parameter int RD_W        = 3,
  parameter int GUARD_CYC   = 10,
  parameter bit ADC_BIPOLAR = 1'b1,
  parameter bit SIGNED_OUT  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  output logic        conv_start,
  input  logic        eoc_n,
  output logic        cs_n,
  output logic        rd_n,
  input  logic [11:0] adc_bus,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [11:0] m_data,
  output logic        err_period,
  output logic        err_timeout
);
  localparam int MIN_PERIOD_CYC = CONV_CYC + ACQ_CYC;
  localparam bit PERIOD_BAD     = (PERIOD_CYC < MIN_PERIOD_CYC);
  localparam bit FLIP           = (ADC_BIPOLAR != SIGNED_OUT);

  logic start_evt, eoc_fall, strobe_n, take, late_err;

  adcc_timer #(.PERIOD_CYC(PERIOD_CYC), .START_W(START_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .conv_start(conv_start), .start_evt(start_evt)
  );

  adcc_eoc_sync u_sync (
    .clk(clk), .rst_n(rst_n), .eoc_n(eoc_n), .eoc_fall(eoc_fall)
  );

  adcc_read_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .RD_W(RD_W), .GUARD_CYC(GUARD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .eoc_fall(eoc_fall),
    .strobe_n(strobe_n), .take(take), .late_err(late_err), .timeout_err(err_timeout)
  );

  adcc_out_reg #(.DATA_W(12), .FLIP(FLIP)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .din(adc_bus),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  assign cs_n       = strobe_n;
  assign rd_n       = strobe_n;
  assign err_period = PERIOD_BAD | late_err;
endmodule

// File: rtl/adcc_checker.sv
module adcc_checker #(
  parameter int RD_W = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        conv_start,
  input logic        eoc_n,
  input logic        rd_n,
  input logic        m_valid,
  input logic        m_ready,
  input logic [11:0] m_data,
  input logic        err_period,
  input logic        err_timeout
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!rd_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_start_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> $past(enable));

  assert_strobe_after_eoc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(eoc_n, 2) == 1'b0));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (low_run == 8'(RD_W)));

  assert_valid_with_strobe_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $rose(rd_n));

  assert_hold_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_period_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_period |=> err_period);

  assert_timeout_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);
endmodule

bind adc_capture_top adcc_checker #(.RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .conv_start(conv_start),
  .eoc_n(eoc_n), .rd_n(rd_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .err_period(err_period), .err_timeout(err_timeout)
);

// File: tb/tb_adc_capture_top.sv
`timescale 1ns/1ps
module tb_adc_capture_top;
  localparam int PER = 40, SW = 2, RDW = 3, GRD = 10, TMO = 36;
  localparam int NV = 6;
  localparam logic [11:0] V_CODE [NV] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'h123, 12'hA5C};
  localparam int          V_LAT  [NV] = '{10, 14, 20, 6, 17, 12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic m_ready = 1'b1;
  logic eoc_model = 1'b1, eoc_force = 1'b1;
  logic eoc_n;
  logic conv_start, cs_n, rd_n, m_valid, err_period, err_timeout;
  logic [11:0] adc_bus, m_data, held_code, next_code;
  int next_lat;
  logic s_cs, s_rd, s_valid, s_per, s_tmo;
  logic [11:0] s_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  assign eoc_n   = eoc_model & eoc_force;
  assign adc_bus = (!cs_n && !rd_n) ? held_code : 12'h5A5;

  adc_capture_top #(.PERIOD_CYC(PER), .START_W(SW), .CONV_CYC(20), .ACQ_CYC(10),
    .TIMEOUT_CYC(TMO), .RD_W(RDW), .GUARD_CYC(GRD), .ADC_BIPOLAR(1'b1), .SIGNED_OUT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .conv_start(conv_start), .eoc_n(eoc_n),
    .cs_n(cs_n), .rd_n(rd_n), .adc_bus(adc_bus), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .err_period(err_period), .err_timeout(err_timeout));

  adc_capture_top #(.PERIOD_CYC(20), .CONV_CYC(20), .ACQ_CYC(10), .TIMEOUT_CYC(18)) dut_short (
    .clk(clk), .rst_n(rst_n), .enable(1'b0), .conv_start(s_cs), .eoc_n(1'b1),
    .cs_n(s_rd), .rd_n(s_tmo), .adc_bus(12'h000), .m_valid(s_valid), .m_ready(1'b1),
    .m_data(s_data), .err_period(s_per), .err_timeout());

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Converter model: latches the pending code and latency on each start rise.
  always @(posedge conv_start) begin
    int lat;
    held_code = next_code;
    lat = next_lat;
    if (lat != 0) begin
      repeat (lat) @(negedge clk);
      eoc_model = 1'b0;
      repeat (2) @(negedge clk);
      eoc_model = 1'b1;
    end
  end

  // Monitors: start spacing and width (R1), strobe pairing and width (R3).
  int hi_run = 0, since_rise = -1, lo_run = 0;
  logic prev_cs = 1'b0, prev_rd = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (conv_start && !prev_cs) begin
      if (since_rise >= 0) chk("R1 start spacing", since_rise, PER);
      since_rise = 0;
    end
    if (!conv_start && prev_cs) chk("R1 start width", hi_run, SW);
    if (conv_start) hi_run++; else hi_run = 0;
    if (since_rise >= 0) since_rise++;
    if (cs_n !== rd_n) chk("R3 cs_n equals rd_n", cs_n, rd_n);
    if (rd_n && !prev_rd) chk("R3 strobe width", lo_run, RDW);
    if (!rd_n) lo_run++; else lo_run = 0;
    prev_cs = conv_start;
    prev_rd = rd_n;
  end

  task automatic receive(input string req, input logic [11:0] exp);
    int t = 0;
    while (!m_valid && t < 200) begin @(negedge clk); t++; end
    chk(req, m_data, exp);
    @(negedge clk);
  endtask

  // R2 timing probe: eoc sampled low at edge k -> strobe low at edge k+2.
  int eoc_edge = -1, edge_no = 0, gap = -1;
  logic eoc_q = 1'b1, rd_q = 1'b1;
  always @(posedge clk) begin
    edge_no++;
    if (eoc_q && !eoc_n) eoc_edge = edge_no;
    #1;
    if (rd_q && !rd_n && eoc_edge >= 0) gap = edge_no - eoc_edge;
    eoc_q = eoc_n;
    rd_q = rd_n;
  end

  initial begin
    next_code = V_CODE[0];
    next_lat  = V_LAT[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset conv_start R1", conv_start, 0);
    chk("reset strobe R3", rd_n, 1);
    chk("reset m_valid R4", m_valid, 0);
    chk("reset err_period R8", err_period, 0);
    chk("reset err_timeout R9", err_timeout, 0);
    chk("short period flag R8", s_per, 1);

    // R10: stray eoc while idle
    eoc_force = 1'b0;
    repeat (2) @(negedge clk);
    eoc_force = 1'b1;
    begin
      logic any_strobe = 1'b0, any_valid = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!cs_n) any_strobe = 1'b1;
        if (m_valid) any_valid = 1'b1;
        if (conv_start) any_strobe = 1'b1;
      end
      chk("R10 stray eoc no strobe", any_strobe, 0);
      chk("R10 stray eoc no output", any_valid, 0);
    end

    // Vector walk: R4 capture, R5 format (bipolar converter, unsigned out -> MSB inverted)
    enable = 1'b1;
    for (int i = 0; i < NV; i++) begin
      receive("R5 format/R4 capture", V_CODE[i] ^ 12'h800);
      if (i == 0) chk("R2 eoc to strobe edges", gap, 2);
      if (i + 1 < NV) begin next_code = V_CODE[i+1]; next_lat = V_LAT[i+1]; end
    end
    chk("R7 no flag in nominal run", err_period, 0);

    // R6 back-pressure
    m_ready = 1'b0;
    next_code = 12'h3C1; next_lat = 12;
    begin
      int t = 0;
      while (!m_valid && t < 200) begin @(negedge clk); t++; end
    end
    chk("R6 first held", m_data, 12'h3C1 ^ 12'h800);
    next_code = 12'h0F0; next_lat = 12;
    repeat (45) @(negedge clk);
    chk("R6 valid held", m_valid, 1);
    chk("R6 second dropped", m_data, 12'h3C1 ^ 12'h800);
    next_code = 12'h456; next_lat = 12;
    m_ready = 1'b1;
    @(negedge clk);
    chk("R6 accepted", m_valid, 0);
    receive("R6 next after release", 12'h456 ^ 12'h800);

    // R7 guard boundary: latency 28 gives exactly GRD cycles, 29 gives one fewer
    next_code = 12'h111; next_lat = 28;
    receive("R7 boundary data", 12'h111 ^ 12'h800);
    next_code = 12'h222; next_lat = 29;
    @(posedge conv_start); repeat (2) @(negedge clk);
    chk("R7 exact guard no flag", err_period, 0);
    receive("R7 late data", 12'h222 ^ 12'h800);
    next_code = 12'h333; next_lat = 0;
    @(posedge conv_start); repeat (2) @(negedge clk);
    chk("R7 late read flagged", err_period, 1);
    chk("R9 no timeout yet", err_timeout, 0);

    // R9 timeout, then recovery
    next_code = 12'h444; next_lat = 15;
    begin
      logic any_valid = 1'b0;
      for (int i = 0; i < 36; i++) begin
        @(negedge clk);
        if (m_valid || !rd_n) any_valid = 1'b1;
      end
      chk("R9 no strobe on timeout", any_valid, 0);
    end
    chk("R9 timeout flag", err_timeout, 1);
    receive("R9 recovery after timeout", 12'h444 ^ 12'h800);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule